// File: doc/BRIEF.md
# 1-Wire Slave Network Addressing Layer

This block sits between a slave bit engine and the function-command layer of a 1-Wire slave. The bit engine reports each bus reset and each completed time slot, with the line value seen in that slot. The layer tells the engine whether to drive the next slot and with which value. It decodes the 8-bit addressing command, then runs one of three sequences: reading out the device identity, matching a received identity, or taking part in the bit-wise search arbitration. A conditional variant of the search takes part only while an external event flag is set. When addressing succeeds, `selected` rises and the function-command layer takes over the slots.

The 64-bit identity comes from two parameters, a family byte and a 48-bit serial number. The check byte is computed at elaboration. The slot interface is a stream with no back-pressure. `slot_stb` is a one-cycle valid, and the layer is always ready, because bus timing is set by the master. `tx_req`/`tx_bit` are a level that holds from the cycle after one strobe until the next strobe. The engine samples them when a slot begins.

Top module: `owr_rom_layer`

## Requirements
- R1: After `rst_n` deasserts, the layer is silent: `tx_req` and `selected` stay 0 and slots are ignored until the first `bus_rst` pulse.
- R2: A `bus_rst` pulse in any state clears `selected`, drops `tx_req`, and restarts command reception. It wins over a `slot_stb` in the same cycle, and that slot is not counted.
- R3: The command is the line value of 8 slots, least significant bit first. Codes are 33h read, 55h match, F0h search, CCh skip and ECh conditional search. Any other code leaves the layer silent until the next bus reset.
- R4: Identity bit 0 is sent first. Bits 7:0 are the family byte, bits 55:8 the serial, and bits 63:56 a check byte. The check byte is the CRC with polynomial x^8+x^5+x^4+1 over bits 0..55 in order: register starts at 0, reflected constant 8Ch.
- R5: After read, the layer requests the next 64 slots with the identity bits in order, then raises `selected` in the cycle after the 64th slot.
- R6: After skip, `selected` rises in the cycle after the 8th command slot.
- R7: After match, 64 slots are compared with the identity bits. If all agree, `selected` rises after the 64th. A single difference makes the layer silent until bus reset, and `selected` stays 0.
- R8: For each identity bit, search uses three slots: drive the bit, drive its complement, then read the master's choice (`tx_req`=0). A choice unequal to the bit makes the layer silent until bus reset. After 64 agreeing choices, `selected` rises.
- R9: For conditional search, `evt_flag` is sampled with the 8th command slot. If it is 1, the layer behaves as in R8. If it is 0, it stays silent until bus reset.
- R10: While `selected` is 1, slots do not affect the layer: `tx_req` stays 0 and `selected` stays 1 until bus reset.
- R11: `tx_req` is 1 only in slots where R5 or R8 has the slave drive, and `tx_req`/`tx_bit` change only in the cycle after a `slot_stb` or `bus_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rst | input | 1 | One-cycle pulse: bus reset seen by the bit engine |
| slot_stb | input | 1 | One-cycle valid: a time slot completed |
| m_bit | input | 1 | Line value sampled in the slot flagged by `slot_stb` |
| evt_flag | input | 1 | Event flag that gates conditional search |
| tx_req | output | 1 | Slave drives the next slot |
| tx_bit | output | 1 | Value to drive when `tx_req` is 1 |
| selected | output | 1 | Addressing succeeded; function layer owns the slots |

## Verification
A bus reset and a slot strobe can arrive in the same cycle. The bench provokes this twice: midway through an identity readout, and while the layer is selected. Each time, the layer must finish in the command-wait state with the slot unrecorded. This is judged at the ports: `selected` and `tx_req` must be low, and a skip command that follows must select after exactly 8 slots. If the stray slot had been counted, the command would be misread.

// File: rtl/owr_pkg.sv
package owr_pkg;
  typedef enum logic [2:0] {
    ST_MUTE, ST_CMD, ST_READ, ST_MATCH, ST_SEARCH, ST_SEL
  } owr_state_e;

  localparam logic [7:0] CMD_READ   = 8'h33;
  localparam logic [7:0] CMD_MATCH  = 8'h55;
  localparam logic [7:0] CMD_SEARCH = 8'hF0;
  localparam logic [7:0] CMD_SKIP   = 8'hCC;
  localparam logic [7:0] CMD_CSRCH  = 8'hEC;

  // reflected x^8+x^5+x^4+1, bit 0 of the body first
  function automatic logic [7:0] crc8_lsb(input logic [55:0] body);
    logic [7:0] c;
    logic fb;
    c = '0;
    for (int i = 0; i < 56; i++) begin
      fb = c[0] ^ body[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction
endpackage

// File: rtl/owr_mod_counter.sv
module owr_mod_counter #(
  parameter int MOD = 64,
  localparam int W = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         at_last
);
  assign at_last = (cnt == W'(MOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= at_last ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/owr_id_store.sv
module owr_id_store #(
  parameter logic [7:0]  FAMILY = 8'h1F,
  parameter logic [47:0] SERIAL = 48'h5A3C_0F96_E1D2,
  localparam int IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx,
  output logic             id_bit
);
  localparam logic [55:0] BODY  = {SERIAL, FAMILY};
  localparam logic [7:0]  CHECK = owr_pkg::crc8_lsb(BODY);
  localparam logic [63:0] IDENT = {CHECK, BODY};

  assign id_bit = IDENT[idx];
endmodule

// File: rtl/owr_rom_layer.sv
module owr_rom_layer #(
  parameter logic [7:0]  FAMILY = 8'h1F,
  parameter logic [47:0] SERIAL = 48'h5A3C_0F96_E1D2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rst,
  input  logic slot_stb,
  input  logic m_bit,
  input  logic evt_flag,
  output logic tx_req,
  output logic tx_bit,
  output logic selected
);
  import owr_pkg::*;

  localparam int ID_W  = 64;
  localparam int IDX_W = $clog2(ID_W);
  localparam int CMD_W = 8;
  localparam int PH_N  = 3;
  localparam int PH_W  = $clog2(PH_N);

  owr_state_e st_q, st_d;
  logic [CMD_W-1:0] cmd_q, cmd_d, cmd_now;
  logic [IDX_W-1:0] idx;
  logic [PH_W-1:0]  ph;
  logic idx_last, ph_last_unused;
  logic idx_clr, idx_inc, ph_clr, ph_inc;
  logic id_bit;

  owr_mod_counter #(.MOD(ID_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr(idx_clr), .inc(idx_inc),
    .cnt(idx), .at_last(idx_last)
  );

  owr_mod_counter #(.MOD(PH_N)) u_ph (
    .clk(clk), .rst_n(rst_n), .clr(ph_clr), .inc(ph_inc),
    .cnt(ph), .at_last(ph_last_unused)
  );

  owr_id_store #(.FAMILY(FAMILY), .SERIAL(SERIAL)) u_id (
    .idx(idx), .id_bit(id_bit)
  );

  assign cmd_now = {m_bit, cmd_q[CMD_W-1:1]};

  always_comb begin
    st_d    = st_q;
    cmd_d   = cmd_q;
    idx_clr = 1'b0;
    idx_inc = 1'b0;
    ph_clr  = 1'b0;
    ph_inc  = 1'b0;
    if (bus_rst) begin
      st_d    = ST_CMD;
      cmd_d   = '0;
      idx_clr = 1'b1;
      ph_clr  = 1'b1;
    end else if (slot_stb) begin
      unique case (st_q)
        ST_CMD: begin
          cmd_d = cmd_now;
          if (idx == IDX_W'(CMD_W - 1)) begin
            idx_clr = 1'b1;
            ph_clr  = 1'b1;
            unique case (cmd_now)
              CMD_READ:   st_d = ST_READ;
              CMD_MATCH:  st_d = ST_MATCH;
              CMD_SEARCH: st_d = ST_SEARCH;
              CMD_SKIP:   st_d = ST_SEL;
              CMD_CSRCH:  st_d = evt_flag ? ST_SEARCH : ST_MUTE;
              default:    st_d = ST_MUTE;
            endcase
          end else begin
            idx_inc = 1'b1;
          end
        end
        ST_READ: begin
          if (idx_last) st_d = ST_SEL;
          else          idx_inc = 1'b1;
        end
        ST_MATCH: begin
          if (m_bit != id_bit) st_d = ST_MUTE;
          else if (idx_last)   st_d = ST_SEL;
          else                 idx_inc = 1'b1;
        end
        ST_SEARCH: begin
          ph_inc = 1'b1;
          if (ph == PH_W'(PH_N - 1)) begin
            if (m_bit != id_bit) st_d = ST_MUTE;
            else if (idx_last)   st_d = ST_SEL;
            else                 idx_inc = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_MUTE;
      cmd_q <= '0;
    end else begin
      st_q  <= st_d;
      cmd_q <= cmd_d;
    end
  end

  always_comb begin
    tx_req = 1'b0;
    tx_bit = 1'b1;
    if (st_q == ST_READ) begin
      tx_req = 1'b1;
      tx_bit = id_bit;
    end else if (st_q == ST_SEARCH && ph != PH_W'(PH_N - 1)) begin
      tx_req = 1'b1;
      tx_bit = (ph == PH_W'(1)) ? ~id_bit : id_bit;
    end
  end

  assign selected = (st_q == ST_SEL);
endmodule

// File: rtl/owr_rom_layer_chk.sv
module owr_rom_layer_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_rst,
  input logic slot_stb,
  input logic tx_req,
  input logic tx_bit,
  input logic selected
);
  assert_rst_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (!selected && !tx_req));

  assert_sel_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && !bus_rst) |=> selected);

  assert_sel_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    selected |-> !tx_req);

  assert_sel_after_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!selected && !slot_stb) |=> !selected);

  assert_tx_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_stb && !bus_rst) |=> ($stable(tx_req) && $stable(tx_bit)));
endmodule

bind owr_rom_layer owr_rom_layer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .slot_stb(slot_stb),
  .tx_req(tx_req), .tx_bit(tx_bit), .selected(selected)
);

// File: tb/sim_owr_rom_layer.sv
module sim_owr_rom_layer;
  localparam logic [7:0]  FAM = 8'h1F;
  localparam logic [47:0] SER = 48'h5A3C_0F96_E1D2;

  logic clk = 1'b0, rst_n = 1'b0, bus_rst = 1'b0, slot_stb = 1'b0;
  logic m_bit = 1'b1, evt_flag = 1'b0;
  logic tx_req, tx_bit, selected;

  int n_vec = 0, n_bad = 0;

  typedef struct { logic req; logic val; string tag; } exp_t;
  exp_t q[$];

  logic [63:0] ident;

  always #5 clk = ~clk;

  owr_rom_layer #(.FAMILY(FAM), .SERIAL(SER)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .slot_stb(slot_stb),
    .m_bit(m_bit), .evt_flag(evt_flag),
    .tx_req(tx_req), .tx_bit(tx_bit), .selected(selected)
  );

  // R4: identity with check byte, computed in the bench
  function automatic logic [63:0] make_id();
    logic [55:0] b;
    logic [7:0] c;
    b = {SER, FAM};
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ 8'h8C;
      else             c = c >> 1;
    end
    return {c, b};
  endfunction

  // monitor: compares what the layer offers for each slot
  always @(negedge clk) begin
    if (slot_stb) begin
      exp_t e;
      if (q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL scoreboard empty: act req=%0b exp none", tx_req);
      end else begin
        e = q.pop_front();
        n_vec++;
        if (tx_req !== e.req || (e.req && tx_bit !== e.val)) begin
          n_bad++;
          $display("FAIL %s: act req=%0b bit=%0b exp req=%0b bit=%0b",
                   e.tag, tx_req, tx_bit, e.req, e.val);
        end
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    @(negedge clk);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic slot(logic mb, logic er, logic ev, string tag);
    exp_t e;
    e.req = er; e.val = ev; e.tag = tag;
    q.push_back(e);
    @(posedge clk); #1;
    m_bit = mb; slot_stb = 1'b1;
    @(posedge clk); #1;
    slot_stb = 1'b0; m_bit = 1'b1;
  endtask

  task automatic brst();
    @(posedge clk); #1 bus_rst = 1'b1;
    @(posedge clk); #1 bus_rst = 1'b0;
  endtask

  task automatic cmd(logic [7:0] c, string tag);
    for (int i = 0; i < 8; i++) slot(c[i], 1'b0, 1'b0, tag);
  endtask

  task automatic read_id(int n, string tag);
    for (int i = 0; i < n; i++) slot(ident[i], 1'b1, ident[i], tag);
  endtask

  task automatic match_id(logic [63:0] v, string tag);
    for (int i = 0; i < 64; i++) slot(v[i], 1'b0, 1'b0, tag);
  endtask

  task automatic search(logic [63:0] pick, logic joins, string tag);
    logic in_play;
    in_play = joins;
    for (int i = 0; i < 64; i++) begin
      if (in_play) begin
        slot(ident[i], 1'b1, ident[i], tag);
        slot(~ident[i], 1'b1, ~ident[i], tag);
      end else begin
        slot(1'b1, 1'b0, 1'b0, tag);
        slot(1'b1, 1'b0, 1'b0, tag);
      end
      slot(pick[i], 1'b0, 1'b0, tag);
      if (pick[i] != ident[i]) in_play = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    ident = make_id();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 reset selected", selected, 1'b0);
    chk("R1 reset tx_req", tx_req, 1'b0);

    // R1: dormant before first bus reset
    cmd(8'hCC, "R1 dormant");
    chk("R1 dormant no select", selected, 1'b0);

    // R6: skip
    brst();
    cmd(8'hCC, "R6 skip cmd");
    chk("R6 skip selects", selected, 1'b1);
    // R10: slots ignored while selected
    cmd(8'h33, "R10 selected slots");
    chk("R10 still selected", selected, 1'b1);

    // R5/R4: read identity
    brst();
    chk("R2 reset clears selected", selected, 1'b0);
    cmd(8'h33, "R3 read cmd");
    read_id(64, "R5 R4 read bit");
    chk("R5 read selects", selected, 1'b1);

    // R7: match ok and mismatch
    brst();
    cmd(8'h55, "R3 match cmd");
    match_id(ident, "R7 match ok");
    chk("R7 match selects", selected, 1'b1);
    brst();
    cmd(8'h55, "R3 match cmd");
    match_id(ident ^ (64'd1 << 40), "R7 match bad");
    chk("R7 mismatch no select", selected, 1'b0);

    // R8: search full and with drop
    brst();
    cmd(8'hF0, "R3 search cmd");
    search(ident, 1'b1, "R8 search");
    chk("R8 search selects", selected, 1'b1);
    brst();
    cmd(8'hF0, "R3 search cmd");
    search(ident ^ (64'd1 << 5), 1'b1, "R8 search drop");
    chk("R8 drop no select", selected, 1'b0);

    // R9: conditional search
    brst();
    evt_flag = 1'b0;
    cmd(8'hEC, "R9 csearch cmd");
    search(ident, 1'b0, "R9 flag clear silent");
    chk("R9 flag clear no select", selected, 1'b0);
    brst();
    evt_flag = 1'b1;
    cmd(8'hEC, "R9 csearch cmd");
    evt_flag = 1'b0;
    search(ident, 1'b1, "R9 flag set");
    chk("R9 flag set selects", selected, 1'b1);

    // R3: unknown code
    brst();
    cmd(8'h96, "R3 unknown cmd");
    read_id(0, "R3");
    slot(1'b1, 1'b0, 1'b0, "R3 unknown silent");
    chk("R3 unknown no select", selected, 1'b0);

    // R2: bus reset together with a slot, mid readout
    brst();
    cmd(8'h33, "R3 read cmd");
    read_id(10, "R5 partial read");
    begin
      exp_t e;
      e.req = 1'b1; e.val = ident[10]; e.tag = "R2 collide read";
      q.push_back(e);
      @(posedge clk); #1;
      bus_rst = 1'b1; slot_stb = 1'b1; m_bit = ident[10];
      @(posedge clk); #1;
      bus_rst = 1'b0; slot_stb = 1'b0; m_bit = 1'b1;
    end
    chk("R2 collide tx_req", tx_req, 1'b0);
    chk("R2 collide selected", selected, 1'b0);
    cmd(8'hCC, "R2 fresh cmd");
    chk("R2 fresh skip selects", selected, 1'b1);

    // R2: collision while selected
    q.push_back('{1'b0, 1'b0, "R2 collide sel"});
    @(posedge clk); #1;
    bus_rst = 1'b1; slot_stb = 1'b1; m_bit = 1'b0;
    @(posedge clk); #1;
    bus_rst = 1'b0; slot_stb = 1'b0; m_bit = 1'b1;
    chk("R2 collide clears selected", selected, 1'b0);
    cmd(8'hCC, "R2 fresh cmd");
    chk("R2 skip after collide", selected, 1'b1);
    chk("R11 no drive when selected", tx_req, 1'b0);

    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule